// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned operands of `K = UPPER_W + LOWER_W` bits and trades exactness in the low bits for a short carry path. The word is split into two parts. The top `UPPER_W` bits form an exact ripple-free binary adder. The bottom `LOWER_W` bits form an inexact part in which each result bit is the OR of the two operand bits at that position, and no carry travels between them. One AND of the operand bits at the highest inexact position is the only carry handed to the exact part. The longest path therefore runs through the exact upper adder only.

The block suits datapaths that can accept small errors, such as filters and pixel arithmetic. An input register stage and an output register stage can each be switched in by parameter, which fixes the latency at `IN_REG + OUT_REG` cycles. With `LOWER_W = 0` the inexact part disappears and the block is an exact adder. The parameters are checked when the design elaborates.

Top module: `loa_adder`

## Requirements
- R1: Each sum bit at position i below LOWER_W equals a[i] OR b[i].
- R2: Sum bits [K-1:LOWER_W] equal the low UPPER_W bits of a[K-1:LOWER_W] + b[K-1:LOWER_W] + (a[LOWER_W-1] AND b[LOWER_W-1]).
- R3: cout_o is the carry out of bit UPPER_W of that upper addition.
- R4: Operand bits below position LOWER_W-1 have no effect on sum bits [K-1:LOWER_W] or on cout_o.
- R5: A result appears on the outputs exactly IN_REG + OUT_REG rising clock edges after its operands are presented. The default is 2.
- R6: While rst_ni is low, and until operands taken after reset reach the outputs, sum_o and cout_o are zero.
- R7: With LOWER_W = 0, {cout_o, sum_o} equals the exact (K+1)-bit sum a + b.
- R8: The (K+1)-bit value {cout_o, sum_o} differs from the exact sum a + b by less than 2^LOWER_W in magnitude.
- R9: The design refuses to elaborate if UPPER_W is below 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | K | First unsigned operand |
| b_i | input | K | Second unsigned operand |
| sum_o | output | K | Approximate sum |
| cout_o | output | 1 | Carry out of the exact upper part |

## Verification
Directed patterns come first. Operands with all ones in the inexact field but a clear top bit show that no carry leaves the lower part. Operands with only the top inexact bit set show that the single AND carry is taken into the exact part. All-ones operands drive both the exact part and the carry out to overflow. Fixed-seed random operands follow, issued back to back to cover latency. Each random result is checked against a bit-accurate model of the OR/AND scheme, and against a copy of the operands with the lower bits masked, which shows those bits have no influence. An exact-configured second instance is compared with true addition, and the error of the approximate instance against true addition is bounded and reported.

// File: rtl/loa_pkg.sv
package loa_pkg;
    localparam int unsigned LOA_DEF_UPPER_W = 10;
    localparam int unsigned LOA_DEF_LOWER_W = 6;
endpackage

// File: rtl/loa_or_lower.sv
module loa_or_lower #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] b_lo,
    output logic [W-1:0] sum_lo,
    output logic         carry_up
);
    always_comb begin
        sum_lo   = a_lo | b_lo;
        carry_up = a_lo[W-1] & b_lo[W-1];
    end
endmodule

// File: rtl/loa_exact_upper.sv
module loa_exact_upper #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] b_hi,
    input  logic         cin,
    output logic [W-1:0] sum_hi,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, a_hi} + {1'b0, b_hi} + {{W{1'b0}}, cin};
        sum_hi = wide[W-1:0];
        cout   = wide[W];
    end
endmodule

// File: rtl/loa_adder.sv
module loa_adder
    import loa_pkg::*;
#(
    parameter int unsigned UPPER_W = LOA_DEF_UPPER_W,
    parameter int unsigned LOWER_W = LOA_DEF_LOWER_W,
    parameter bit          IN_REG  = 1'b1,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [UPPER_W+LOWER_W-1:0] a_i,
    input  logic [UPPER_W+LOWER_W-1:0] b_i,
    output logic [UPPER_W+LOWER_W-1:0] sum_o,
    output logic                       cout_o
);
    localparam int unsigned K = UPPER_W + LOWER_W;

    typedef struct packed {
        logic [K-1:0] a;
        logic [K-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic         cout;
        logic [K-1:0] sum;
    } res_t;

    // R9: upper exact part must exist
    if (UPPER_W < 1) begin : g_bad_upper
        $error("loa_adder: UPPER_W must be at least 1");
    end

    opnd_t              opnd_d;
    opnd_t              opnd;
    res_t               res_d;
    res_t               res;
    logic               carry_mid;
    logic [UPPER_W-1:0] up_sum;
    logic               up_cout;
    logic [K-1:0]       sum_full;

    always_comb begin
        opnd_d.a = a_i;
        opnd_d.b = b_i;
    end

    if (IN_REG) begin : g_in_reg
        opnd_t opnd_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                opnd_q <= '0;
            end else begin
                opnd_q <= opnd_d;
            end
        end
        assign opnd = opnd_q;
    end else begin : g_in_pass
        assign opnd = opnd_d;
    end

    if (LOWER_W > 0) begin : g_lower
        logic [LOWER_W-1:0] lo_sum;
        loa_or_lower #(.W(LOWER_W)) u_lower (
            .a_lo     (opnd.a[LOWER_W-1:0]),
            .b_lo     (opnd.b[LOWER_W-1:0]),
            .sum_lo   (lo_sum),
            .carry_up (carry_mid)
        );
        assign sum_full = {up_sum, lo_sum};
    end else begin : g_exact_only
        assign carry_mid = 1'b0;
        assign sum_full  = up_sum;
    end

    loa_exact_upper #(.W(UPPER_W)) u_upper (
        .a_hi   (opnd.a[K-1:LOWER_W]),
        .b_hi   (opnd.b[K-1:LOWER_W]),
        .cin    (carry_mid),
        .sum_hi (up_sum),
        .cout   (up_cout)
    );

    always_comb begin
        res_d.cout = up_cout;
        res_d.sum  = sum_full;
    end

    if (OUT_REG) begin : g_out_reg
        res_t res_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
        assign res = res_q;
    end else begin : g_out_pass
        assign res = res_d;
    end

    assign sum_o  = res.sum;
    assign cout_o = res.cout;
endmodule

// File: rtl/loa_adder_chk.sv
module loa_adder_chk #(
    parameter int unsigned UPPER_W = 10,
    parameter int unsigned LOWER_W = 6,
    parameter bit          IN_REG  = 1'b1,
    parameter bit          OUT_REG = 1'b1
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [UPPER_W+LOWER_W-1:0] a_i,
    input logic [UPPER_W+LOWER_W-1:0] b_i,
    input logic [UPPER_W+LOWER_W-1:0] sum_o,
    input logic                       cout_o
);
    localparam int unsigned K   = UPPER_W + LOWER_W;
    localparam int unsigned LAT = 32'(IN_REG) + 32'(OUT_REG);

    logic [K-1:0] dly_a [0:LAT];
    logic [K-1:0] dly_b [0:LAT];
    logic [1:0]   since_rst;

    assign dly_a[0] = a_i;
    assign dly_b[0] = b_i;

    for (genvar gi = 1; gi <= LAT; gi++) begin : g_dly
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                dly_a[gi] <= '0;
                dly_b[gi] <= '0;
            end else begin
                dly_a[gi] <= dly_a[gi-1];
                dly_b[gi] <= dly_b[gi-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    logic [K-1:0]        ea;
    logic [K-1:0]        eb;
    logic [K:0]          true_sum;
    logic [UPPER_W:0]    up_ref;
    logic                mid_c;
    logic signed [K+1:0] err;
    logic signed [K+1:0] bound;

    always_comb begin
        ea       = dly_a[LAT];
        eb       = dly_b[LAT];
        true_sum = {1'b0, ea} + {1'b0, eb};
        mid_c    = (LOWER_W > 0) ? (ea[(LOWER_W > 0) ? LOWER_W-1 : 0] & eb[(LOWER_W > 0) ? LOWER_W-1 : 0]) : 1'b0;
        up_ref   = {1'b0, ea[K-1:LOWER_W]} + {1'b0, eb[K-1:LOWER_W]} + {{UPPER_W{1'b0}}, mid_c};
        err      = $signed({1'b0, true_sum}) - $signed({1'b0, cout_o, sum_o});
        bound    = $signed((K+2)'(1) << LOWER_W);
    end

    if (LOWER_W > 0) begin : g_lo_chk
        assert_lower_or_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sum_o[LOWER_W-1:0] == (ea[LOWER_W-1:0] | eb[LOWER_W-1:0]));
    end

    assert_upper_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_o[K-1:LOWER_W] == up_ref[UPPER_W-1:0]);

    assert_carry_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cout_o == up_ref[UPPER_W]);

    assert_reset_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(since_rst) < LAT) |-> (sum_o == '0 && !cout_o));

    assert_err_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err < bound) && (err > -bound));
endmodule

bind loa_adder loa_adder_chk #(
    .UPPER_W (UPPER_W),
    .LOWER_W (LOWER_W),
    .IN_REG  (IN_REG),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/loa_adder_test.sv
`timescale 1ns/100ps
module loa_adder_test;
    localparam int M  = 10;
    localparam int N  = 6;
    localparam int K  = 16;
    localparam int ND = 12;
    localparam int NR = 600;
    localparam int NV = ND + NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [K-1:0]  a = '0;
    logic [K-1:0]  b = '0;
    logic [K-1:0]  sum_apx, sum_ex;
    logic          c_apx, c_ex;

    int n_cmp = 0;
    int n_bad = 0;
    int max_err = 0;
    bit done = 1'b0;

    logic [K-1:0] va [0:NV-1];
    logic [K-1:0] vb [0:NV-1];

    always #2.5 clk = ~clk;

    loa_adder #(.UPPER_W(M), .LOWER_W(N), .IN_REG(1'b1), .OUT_REG(1'b1)) uut (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sum_o(sum_apx), .cout_o(c_apx)
    );

    loa_adder #(.UPPER_W(K), .LOWER_W(0), .IN_REG(1'b1), .OUT_REG(1'b1)) uut_exact (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sum_o(sum_ex), .cout_o(c_ex)
    );

    function automatic logic [K:0] model_loa(logic [K-1:0] x, logic [K-1:0] y);
        logic [N-1:0] lo;
        logic         c;
        logic [M:0]   hi;
        lo = x[N-1:0] | y[N-1:0];
        c  = x[N-1] & y[N-1];
        hi = {1'b0, x[K-1:N]} + {1'b0, y[K-1:N]} + {{M{1'b0}}, c};
        return {hi, lo};
    endfunction

    function automatic logic [K:0] model_exact(logic [K-1:0] x, logic [K-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("max |approx - exact| observed: %0d", max_err);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check_vec(int idx);
        logic [K:0] exp, exp_m, ex, act;
        logic [K-1:0] mask;
        int e;
        mask  = ~(K'((1 << (N - 1)) - 1));
        exp   = model_loa(va[idx], vb[idx]);
        exp_m = model_loa(va[idx] & mask, vb[idx] & mask);
        ex    = model_exact(va[idx], vb[idx]);
        act   = {c_apx, sum_apx};
        check("R1 lower OR bits (R5 latency)", 32'(act[N-1:0]), 32'(exp[N-1:0]));
        check("R2 upper exact sum", 32'(act[K-1:N]), 32'(exp[K-1:N]));
        check("R3 carry out", 32'(act[K]), 32'(exp[K]));
        check("R4 lower bits no effect", 32'(act[K:N]), 32'(exp_m[K:N]));
        check("R7 exact when LOWER_W=0", 32'({c_ex, sum_ex}), 32'(ex));
        e = int'(ex) - int'(act);
        if (e < 0) e = -e;
        if (e > max_err) max_err = e;
        check("R8 error bound", 32'(e < (1 << N)), 32'd1);
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        va[0]  = 16'h001F; vb[0]  = 16'h001F;
        va[1]  = 16'h0020; vb[1]  = 16'h0020;
        va[2]  = 16'hFFFF; vb[2]  = 16'hFFFF;
        va[3]  = 16'h0000; vb[3]  = 16'h0000;
        va[4]  = 16'hFFC0; vb[4]  = 16'h0040;
        va[5]  = 16'hFFE0; vb[5]  = 16'h0020;
        va[6]  = 16'h003F; vb[6]  = 16'h0000;
        va[7]  = 16'h0015; vb[7]  = 16'h002A;
        va[8]  = 16'h8000; vb[8]  = 16'h8000;
        va[9]  = 16'h7FFF; vb[9]  = 16'h0001;
        va[10] = 16'h1234; vb[10] = 16'h4321;
        va[11] = 16'hFFDF; vb[11] = 16'h0020;
        for (int i = ND; i < NV; i++) begin
            va[i] = 16'($urandom());
            vb[i] = 16'($urandom());
        end

        // reset with nonzero operands applied
        a = 16'hFFFF;
        b = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R6 zero in reset", 32'({c_apx, sum_apx}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 zero before first result", 32'({c_apx, sum_apx}), 32'd0);

        // back-to-back stream, result due two edges after drive
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) check_vec(i - 2);
            if (i < NV) begin
                a = va[i];
                b = vb[i];
            end
            @(negedge clk);
        end
        finish_run();
    end
endmodule